// File: doc/BRIEF.md
# Sliding Window Jet Finder

The block looks for jet candidates in a square patch of calorimeter towers. On each accepted strobe it takes a 16×16 grid of towers. Each tower carries an electromagnetic and a hadronic energy. The inner 8×8 towers form the processing core, and the outer four-tower ring is there only to feed windows centred near the core edge. For every core tower the block adds the two energies and sums the totals over up to three square windows. Each window size is set separately for each frame. It then marks as regions of interest the core towers whose seed-window energy is a local maximum above a threshold, with a fixed rule that settles equal neighbours.

A new grid may arrive on every clock. Each result leaves the pipeline a fixed number of cycles later, carrying the tag that came in with its grid. The result is a flag bitmap over the core and the window energies of every core tower. A downstream stage reads the energies at the flagged positions.

Top module: `swj_jet_finder`

## Requirements
- R1: While reset is asserted, and in the cycle after a reset edge, `out_valid` is low and `roi_flag` is all zeros.
- R2: A grid accepted on a clock edge with `in_valid` high produces exactly one result, with `out_valid` high, four edges later. Its `out_tag` equals the `in_tag` it arrived with, and back-to-back grids come out in order.
- R3: A tower's total is the unsigned sum of its two energies. Window slot s has the 3-bit code `win_code[3s+2:3s]`, and a code k gives a (2k+1)×(2k+1) window centred on the tower. Codes above 4 act as 4. Towers outside the 16×16 grid contribute zero.
- R4: Each window energy saturates at 2^OW−1 (4095 by default).
- R5: The seed window is slot 0. A core tower at row r and column c wins when its seed sum is strictly greater than the seed sums at (r+1, c−1..c+1) and (r, c+1), and at least equal to those at (r−1, c−1..c+1) and (r, c−1). Neighbours in the ring take part, with their windows clipped at the grid edge.
- R6: A winner is flagged only when its seed sum is strictly greater than `seed_thr`.
- R7: Grid tower (row, col) sits at index row·16+col in `grid_em` and `grid_had`, 8 bits per tower. Core position (i, j), which is grid tower (i+4, j+4), is bit i·8+j of `roi_flag`. Its slot-s energy sits at bits [(s·64+i·8+j)·12 +: 12] of `roi_energy`.
- R8: The window codes and the threshold are taken with each grid, so a change between consecutive grids applies only to the grids that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Grid strobe |
| in_tag | input | 8 | Frame tag of the grid |
| grid_em | input | 2048 | Electromagnetic energies, 8 bits per tower |
| grid_had | input | 2048 | Hadronic energies, 8 bits per tower |
| win_code | input | 9 | Three 3-bit window size codes |
| seed_thr | input | 12 | Seed energy threshold |
| out_valid | output | 1 | Result strobe |
| out_tag | output | 8 | Tag of the result |
| roi_flag | output | 64 | Region-of-interest flag per core tower |
| roi_energy | output | 2304 | Window energies, three slots × 64 towers × 12 bits |

## Verification
Every result is due exactly four clock edges after the edge that took its grid. The bench records the cycle in which it drove each tag and checks that the matching `out_valid` comes in the cycle four later, not earlier and not later. It samples outputs on the falling edge and compares the flags and all 192 energies against its own arithmetic model. That model is evaluated for that frame's grid, codes and threshold. Because grids are sent back to back, a stage that held or mixed frames would show up as a tag, latency or value mismatch.

// File: rtl/swj_pkg.sv
// Shared constants and helpers of the sliding window jet finder.
// Assumes window codes are three bits wide and clamped to the environment depth.
package swj_pkg;
    localparam int CODE_W = 3;

    // Clamp a window code to the largest radius the environment supports.
    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] code, input int lim);
        return (int'(code) > lim) ? CODE_W'(lim) : code;
    endfunction
endpackage

// File: rtl/swj_tower_sum.sv
// Stage A: registers the total energy of every tower (em + had, unsigned).
// Assumes both energies share the width EW; the total is one bit wider.
module swj_tower_sum #(
    parameter int NT = 256,
    parameter int EW = 8
) (
    input  logic             clk,
    input  logic [NT*EW-1:0] em_i,
    input  logic [NT*EW-1:0] had_i,
    output logic [NT*(EW+1)-1:0] tot_o
);
    localparam int TW = EW + 1;

    for (genvar t = 0; t < NT; t++) begin : g_tow
        logic [TW-1:0] tot_q;
        // Add the two energies of tower t.
        always_ff @(posedge clk) begin
            tot_q <= {1'b0, em_i[t*EW +: EW]} + {1'b0, had_i[t*EW +: EW]};
        end
        assign tot_o[t*TW +: TW] = tot_q;
    end
endmodule

// File: rtl/swj_win_sum.sv
// Stages B and C: separable square window sum over an N x N region of centres
// starting at grid row/column LO. Rows are summed first, then columns.
// Towers outside the grid count as zero; the result saturates at 2^OW-1.
// Assumes rad_i <= ENV and OW is narrower than the internal sum width.
module swj_win_sum
    import swj_pkg::*;
#(
    parameter int GRID = 16,
    parameter int ENV  = 4,
    parameter int TW   = 9,
    parameter int OW   = 12,
    parameter int LO   = 4,
    parameter int N    = 8
) (
    input  logic                   clk,
    input  logic [GRID*GRID*TW-1:0] tot_i,
    input  logic [CODE_W-1:0]      rad_i,
    output logic [N*N*OW-1:0]      win_o
);
    localparam int WMAX = 2 * ENV + 1;
    localparam int HW   = TW + $clog2(WMAX);
    localparam int SW   = HW + $clog2(WMAX);

    logic [HW-1:0]     h_n [GRID][N];
    logic [HW-1:0]     h_q [GRID][N];
    logic [CODE_W-1:0] rad_q;
    logic [OW-1:0]     v_n [N][N];
    logic [OW-1:0]     v_q [N][N];

    // Horizontal partial sums for every grid row at each centre column.
    always_comb begin
        for (int r = 0; r < GRID; r++) begin
            for (int j = 0; j < N; j++) begin
                logic [HW-1:0] acc;
                acc = '0;
                for (int d = -ENV; d <= ENV; d++) begin
                    int c;
                    c = LO + j + d;
                    if (c >= 0 && c < GRID && ((d < 0) ? -d : d) <= int'(rad_i))
                        acc = acc + HW'(tot_i[(r*GRID+c)*TW +: TW]);
                end
                h_n[r][j] = acc;
            end
        end
    end

    // Register the row sums with the radius of their frame.
    always_ff @(posedge clk) begin
        h_q   <= h_n;
        rad_q <= rad_i;
    end

    // Vertical sums of the row sums, saturated to the output width.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                logic [SW-1:0] acc;
                acc = '0;
                for (int d = -ENV; d <= ENV; d++) begin
                    int r;
                    r = LO + i + d;
                    if (r >= 0 && r < GRID && ((d < 0) ? -d : d) <= int'(rad_q))
                        acc = acc + SW'(h_q[r][j]);
                end
                v_n[i][j] = (acc > SW'({OW{1'b1}})) ? {OW{1'b1}} : OW'(acc);
            end
        end
    end

    // Register the window sums.
    always_ff @(posedge clk) begin
        v_q <= v_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign win_o[(i*N+j)*OW +: OW] = v_q[i][j];
        end
    end
endmodule

// File: rtl/swj_peak.sv
// Stage D: local-maximum search with directional tie-break and threshold.
// seed_i holds seed-window sums over the core plus a one-tower ring
// ((CORE+2)^2 entries, row-major); ext_i holds the other slots over the core.
// Assumes at least two window slots (NX >= 1).
module swj_peak #(
    parameter int CORE = 8,
    parameter int OW   = 12,
    parameter int NX   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(CORE+2)*(CORE+2)*OW-1:0] seed_i,
    input  logic [OW-1:0]                 thr_i,
    input  logic [NX*CORE*CORE*OW-1:0]    ext_i,
    output logic [CORE*CORE-1:0]          flag_o,
    output logic [(NX+1)*CORE*CORE*OW-1:0] energy_o
);
    localparam int NC = CORE * CORE;
    localparam int SN = CORE + 2;

    logic [NC-1:0]           flag_n, flag_q;
    logic [(NX+1)*NC*OW-1:0] en_n, en_q;
    logic [OW-1:0]           thr_q;

    // Local maximum test and output energy assembly for every core tower.
    always_comb begin
        en_n = en_q;
        for (int i = 0; i < CORE; i++) begin
            for (int j = 0; j < CORE; j++) begin
                logic [OW-1:0] ctr;
                logic          win;
                ctr = seed_i[((i+1)*SN + j+1)*OW +: OW];
                win = 1'b1;
                for (int di = -1; di <= 1; di++) begin
                    for (int dj = -1; dj <= 1; dj++) begin
                        logic [OW-1:0] nb;
                        nb = seed_i[((i+1+di)*SN + j+1+dj)*OW +: OW];
                        if (di > 0 || (di == 0 && dj > 0))
                            win = win & (ctr > nb);
                        else if (di != 0 || dj != 0)
                            win = win & (ctr >= nb);
                    end
                end
                flag_n[i*CORE+j] = win & (ctr > thr_i);
                en_n[(i*CORE+j)*OW +: OW] = ctr;
            end
        end
        en_n[(NX+1)*NC*OW-1:NC*OW] = ext_i;
    end

    // Register flags (reset to zero) and energies.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_n;
        en_q  <= en_n;
        thr_q <= thr_i;
    end

    assign flag_o   = flag_q;
    assign energy_o = en_q;

    logic adj_bad, low_bad;
    // Scan the registered flags for flagged neighbours and sub-threshold winners.
    always_comb begin
        adj_bad = 1'b0;
        low_bad = 1'b0;
        for (int i = 0; i < CORE; i++) begin
            for (int j = 0; j < CORE; j++) begin
                if (flag_q[i*CORE+j]) begin
                    if (en_q[(i*CORE+j)*OW +: OW] <= thr_q) low_bad = 1'b1;
                    if (j < CORE-1 && flag_q[i*CORE+j+1]) adj_bad = 1'b1;
                    if (i < CORE-1 && flag_q[(i+1)*CORE+j]) adj_bad = 1'b1;
                    if (i < CORE-1 && j < CORE-1 && flag_q[(i+1)*CORE+j+1]) adj_bad = 1'b1;
                    if (i < CORE-1 && j > 0 && flag_q[(i+1)*CORE+j-1]) adj_bad = 1'b1;
                end
            end
        end
    end

    // R5
    no_adjacent_peaks_chk: assert property (@(posedge clk) disable iff (!rst_n) !adj_bad);
    // R6
    flag_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n) !low_bad);
endmodule

// File: rtl/swj_jet_finder.sv
// Top of the sliding window jet finder. Pipeline: A tower totals, B row sums,
// C column sums with saturation, D peak search. Fixed latency of four edges.
// Slot 0 is the seed window; it is also evaluated on a one-tower ring around
// the core so edge towers can be compared with their outer neighbours.
// Assumes NWIN >= 2 and ENV >= 1.
module swj_jet_finder
    import swj_pkg::*;
#(
    parameter int CORE = 8,
    parameter int ENV  = 4,
    parameter int EW   = 8,
    parameter int OW   = 12,
    parameter int NWIN = 3,
    parameter int TAGW = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [TAGW-1:0]                          in_tag,
    input  logic [(CORE+2*ENV)*(CORE+2*ENV)*EW-1:0]  grid_em,
    input  logic [(CORE+2*ENV)*(CORE+2*ENV)*EW-1:0]  grid_had,
    input  logic [NWIN*3-1:0]                        win_code,
    input  logic [OW-1:0]                            seed_thr,
    output logic                                     out_valid,
    output logic [TAGW-1:0]                          out_tag,
    output logic [CORE*CORE-1:0]                     roi_flag,
    output logic [NWIN*CORE*CORE*OW-1:0]             roi_energy
);
    localparam int GRID = CORE + 2 * ENV;
    localparam int NT   = GRID * GRID;
    localparam int TW   = EW + 1;
    localparam int NC   = CORE * CORE;
    localparam int SN   = CORE + 2;
    localparam int LAT  = 4;

    logic [NT*TW-1:0]  tot;
    logic [CODE_W-1:0] rad_n [NWIN];
    logic [CODE_W-1:0] rad_p [LAT][NWIN];
    logic [OW-1:0]     thr_p [LAT];
    logic [TAGW-1:0]   tag_p [LAT];
    logic [LAT-1:0]    vld_p;

    // Clamp the incoming window codes to radii.
    always_comb begin
        for (int s = 0; s < NWIN; s++) rad_n[s] = clamp_code(win_code[s*3 +: 3], ENV);
    end

    // Valid shift register; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_p <= '0;
        else        vld_p <= {vld_p[LAT-2:0], in_valid};
    end

    // Carry tag, threshold and radii alongside their frame.
    always_ff @(posedge clk) begin
        tag_p[0] <= in_tag;
        thr_p[0] <= seed_thr;
        rad_p[0] <= rad_n;
        for (int k = 1; k < LAT; k++) begin
            tag_p[k] <= tag_p[k-1];
            thr_p[k] <= thr_p[k-1];
            rad_p[k] <= rad_p[k-1];
        end
    end

    swj_tower_sum #(.NT(NT), .EW(EW)) u_tow (
        .clk(clk), .em_i(grid_em), .had_i(grid_had), .tot_o(tot)
    );

    logic [SN*SN*OW-1:0]          seed_sum;
    logic [(NWIN-1)*NC*OW-1:0]    ext_sum;

    swj_win_sum #(.GRID(GRID), .ENV(ENV), .TW(TW), .OW(OW), .LO(ENV-1), .N(SN)) u_seed (
        .clk(clk), .tot_i(tot), .rad_i(rad_p[0][0]), .win_o(seed_sum)
    );

    for (genvar s = 1; s < NWIN; s++) begin : g_slot
        swj_win_sum #(.GRID(GRID), .ENV(ENV), .TW(TW), .OW(OW), .LO(ENV), .N(CORE)) u_win (
            .clk(clk), .tot_i(tot), .rad_i(rad_p[0][s]),
            .win_o(ext_sum[(s-1)*NC*OW +: NC*OW])
        );
    end

    swj_peak #(.CORE(CORE), .OW(OW), .NX(NWIN-1)) u_peak (
        .clk(clk), .rst_n(rst_n), .seed_i(seed_sum), .thr_i(thr_p[2]),
        .ext_i(ext_sum), .flag_o(roi_flag), .energy_o(roi_energy)
    );

    assign out_valid = vld_p[LAT-1];
    assign out_tag   = tag_p[LAT-1];

    logic [3:0] inflight;
    // Count frames between entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + 4'(in_valid) - 4'(out_valid);
    end

    logic mono_bad;
    // A window at least as wide as the seed window never reports less energy.
    always_comb begin
        mono_bad = 1'b0;
        for (int s = 1; s < NWIN; s++) begin
            for (int k = 0; k < NC; k++) begin
                if (out_valid && rad_p[LAT-1][s] >= rad_p[LAT-1][0] &&
                    roi_energy[(s*NC+k)*OW +: OW] < roi_energy[k*OW +: OW])
                    mono_bad = 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && roi_flag == '0));
    // R2
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight <= 4'(LAT)) && (out_valid -> inflight != '0));
    // R3
    window_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n) !mono_bad);
endmodule

// File: tb/swj_jet_finder_tb.sv
module swj_jet_finder_tb;
    localparam int G = 16, C = 8, OW = 12, NW = 3, NC = 64, SAT = 4095;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [7:0] in_tag = '0;
    logic [G*G*8-1:0] grid_em = '0, grid_had = '0;
    logic [8:0] win_code = '0;
    logic [OW-1:0] seed_thr = '0;
    logic out_valid;
    logic [7:0] out_tag;
    logic [NC-1:0] roi_flag;
    logic [NW*NC*OW-1:0] roi_energy;

    swj_jet_finder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .grid_em(grid_em), .grid_had(grid_had), .win_code(win_code),
        .seed_thr(seed_thr), .out_valid(out_valid), .out_tag(out_tag),
        .roi_flag(roi_flag), .roi_energy(roi_energy)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, sent = 0, rcvd = 0;
    int em [G*G], had [G*G], tot [G][G];
    logic [NC-1:0] exp_flag [256];
    int exp_e [256][NW*NC];
    int sent_cyc [256];
    string exp_lbl [256];
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(int m);
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr[15:0]) % m;
    endfunction

    function automatic int wsum(int r, int c, int rad);
        int s = 0;
        for (int dr = -rad; dr <= rad; dr++)
            for (int dc = -rad; dc <= rad; dc++)
                if (r+dr >= 0 && r+dr < G && c+dc >= 0 && c+dc < G) s += tot[r+dr][c+dc];
        return (s > SAT) ? SAT : s;
    endfunction

    task automatic clear_grid();
        for (int t = 0; t < G*G; t++) begin em[t] = 0; had[t] = 0; end
    endtask

    // Drive one grid for one cycle and record its expected result.
    task automatic send(string lbl, int c0, int c1, int c2, int thr);
        int rad [NW];
        int seed [C+2][C+2];
        int tg;
        tg = sent % 256;
        for (int t = 0; t < G*G; t++) begin
            grid_em[t*8 +: 8] = 8'(em[t]);
            grid_had[t*8 +: 8] = 8'(had[t]);
            tot[t/G][t%G] = em[t] + had[t];
        end
        win_code = {3'(c2), 3'(c1), 3'(c0)};
        seed_thr = OW'(thr);
        in_tag = 8'(tg);
        in_valid = 1'b1;
        rad[0] = (c0 > 4) ? 4 : c0;
        rad[1] = (c1 > 4) ? 4 : c1;
        rad[2] = (c2 > 4) ? 4 : c2;
        for (int i = 0; i < C+2; i++)
            for (int j = 0; j < C+2; j++) seed[i][j] = wsum(i+3, j+3, rad[0]);
        for (int i = 0; i < C; i++)
            for (int j = 0; j < C; j++) begin
                int ctr;
                bit win;
                ctr = seed[i+1][j+1];
                win = 1;
                for (int di = -1; di <= 1; di++)
                    for (int dj = -1; dj <= 1; dj++) begin
                        if (di > 0 || (di == 0 && dj > 0)) begin
                            if (!(ctr > seed[i+1+di][j+1+dj])) win = 0;
                        end else if (di != 0 || dj != 0) begin
                            if (!(ctr >= seed[i+1+di][j+1+dj])) win = 0;
                        end
                    end
                exp_flag[tg][i*C+j] = win && (ctr > thr);
                exp_e[tg][i*C+j] = ctr;
                exp_e[tg][NC+i*C+j] = wsum(i+4, j+4, rad[1]);
                exp_e[tg][2*NC+i*C+j] = wsum(i+4, j+4, rad[2]);
            end
        exp_lbl[tg] = lbl;
        sent_cyc[tg] = cyc;
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Compare each result with its expected frame.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int tg;
            int bad_k;
            tg = rcvd % 256;
            checks++;
            if (out_tag != 8'(tg)) begin
                fails++;
                $display("FAIL R2 tag order: got %0d expected %0d", out_tag, tg);
            end
            checks++;
            if (cyc != sent_cyc[tg] + 4) begin
                fails++;
                $display("FAIL R2 latency: got %0d expected %0d", cyc - sent_cyc[tg], 4);
            end
            checks++;
            if (roi_flag != exp_flag[tg]) begin
                fails++;
                $display("FAIL %s flags tag %0d: got %h expected %h", exp_lbl[tg], tg, roi_flag, exp_flag[tg]);
            end
            checks++;
            bad_k = -1;
            for (int k = 0; k < NW*NC; k++)
                if (bad_k < 0 && int'(roi_energy[k*OW +: OW]) != exp_e[tg][k]) bad_k = k;
            if (bad_k >= 0) begin
                fails++;
                $display("FAIL %s energy tag %0d idx %0d: got %0d expected %0d", exp_lbl[tg], tg,
                         bad_k, roi_energy[bad_k*OW +: OW], exp_e[tg][bad_k]);
            end
            rcvd++;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d results expected %0d", rcvd, sent);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_grid();
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        checks++;
        if (out_valid !== 1'b0 || roi_flag !== '0) begin
            fails++;
            $display("FAIL R1 reset: got valid %b flags %h expected 0 0", out_valid, roi_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: got %b expected 0", out_valid);
        end

        // R7: single spike swept over every core position, back to back
        for (int p = 0; p < NC; p++) begin
            clear_grid();
            em[(p/C+4)*G + p%C+4] = 100;
            had[(p/C+4)*G + p%C+4] = 23;
            send("R7", 0, 1, 4, 0);
        end

        // R3: random grids, several window sizes
        for (int f = 0; f < 16; f++) begin
            for (int t = 0; t < G*G; t++) begin em[t] = rnd(16); had[t] = rnd(16); end
            send("R3", f % 3, 1 + f % 3, 2 + f % 3, 20);
        end
        // R3: codes above 4 act as 4
        send("R3", 0, 5, 7, 10);

        // R4: saturation with full towers and with large random towers
        for (int t = 0; t < G*G; t++) begin em[t] = 255; had[t] = 255; end
        send("R4", 0, 3, 4, 0);
        for (int t = 0; t < G*G; t++) begin em[t] = 150 + rnd(106); had[t] = rnd(256); end
        send("R4", 1, 2, 4, 100);

        // R5: equal neighbours horizontally, vertically, diagonally, and a 2x2 plateau
        clear_grid(); em[7*G+7] = 40; em[7*G+8] = 40; send("R5", 0, 1, 2, 0);
        clear_grid(); em[7*G+7] = 40; em[8*G+7] = 40; send("R5", 0, 1, 2, 0);
        clear_grid(); em[7*G+7] = 40; em[8*G+8] = 40; send("R5", 0, 1, 2, 0);
        clear_grid(); em[5*G+9] = 40; em[6*G+10] = 40; send("R5", 0, 1, 2, 0);
        clear_grid();
        em[9*G+9] = 30; em[9*G+10] = 30; em[10*G+9] = 30; em[10*G+10] = 30;
        send("R5", 0, 1, 2, 0);
        // R5: edge core tower against a larger ring neighbour
        clear_grid(); em[4*G+4] = 50; em[3*G+4] = 60; send("R5", 0, 1, 2, 0);
        // R5: seed window of 3 merges nearby towers
        clear_grid(); em[6*G+6] = 20; em[6*G+8] = 20; em[8*G+7] = 20; send("R5", 1, 2, 3, 0);

        // R6: threshold boundary, equal then one below
        clear_grid(); em[8*G+8] = 50; send("R6", 0, 1, 2, 50);
        send("R6", 0, 1, 2, 49);

        // R8: same grid, codes and threshold changed every frame
        for (int t = 0; t < G*G; t++) begin em[t] = rnd(32); had[t] = rnd(32); end
        send("R8", 0, 4, 2, 5);
        send("R8", 2, 0, 4, 60);
        send("R8", 4, 3, 1, 300);
        send("R8", 1, 1, 1, 0);

        repeat (10) @(negedge clk);
        checks++;
        if (rcvd != sent) begin
            fails++;
            $display("FAIL R2 result count: got %0d expected %0d", rcvd, sent);
        end
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule